// File: doc/BRIEF.md
# SPI In-System Programming Target

This block is the target side of a serial programming port. A host holds the session pin low, then shifts fixed four-byte instruction frames into the block over an SPI mode 0 link: MOSI is sampled on the rising SCK edge and MISO changes on the falling edge, most significant bit first. The block decodes each completed frame and acts on a word-wide program memory, a one-page staging buffer and a byte-wide EEPROM, all held inside the block. Read data comes back on MISO while the host shifts the fourth byte.

A session opens with an enable handshake. Until that handshake has been seen, no write, load or erase has any effect and reads return zero. Each erase or write starts a busy timer. Its length is computed from a clock-rate parameter and a per-operation duration in microseconds, and it shows on the `busy` output. While the timer runs, further modifying frames are dropped, but reads are still answered. Raising the session pin closes the session and returns the serial logic to its idle state.

SCK, MOSI and the session pin are asynchronous to `clk`. They are brought into the core clock domain through two-flop synchronisers, so SCK must run well below the core clock (each SCK phase at least four core cycles).

Top module: `isp_target`

## Requirements
- R1: Every frame is exactly 32 SCK cycles (four bytes). Bits travel most significant bit first in both directions. For a read, the fourth byte on MISO carries the addressed data.
- R2: The enable handshake is first byte 0xAC, second byte 0x53, and two don't-care bytes. It is taken only while `tgt_rst` is low. Before it, writes, loads and erases change nothing and leave `busy` low, and reads return 0x00.
- R3: A frame with first byte 0xAC and second-byte bits [7:5] = 100 erases everything. Afterwards every program-memory byte and every EEPROM byte reads 0xFF, and `busy` stays high for exactly CLK_KHZ*ERASE_US/1000 cycles.
- R4: A program-memory read has first byte 0010_H000. The word address is the low PM_AW bits of {byte2, byte3}. H=1 returns the high byte and H=0 returns the low byte.
- R5: A page load has first byte 0100_H000. It writes byte 4 into the high (H=1) or low half of staging word byte3[PG_W-1:0]. A page write has first byte 0x4C. It copies the whole staging buffer to the page given by the {byte2, byte3} word-address bits above PG_W, refills the buffer with all ones, and holds `busy` for CLK_KHZ*FLASH_US/1000 cycles.
- R6: An EEPROM read has first byte 0xA0 and an EEPROM write has first byte 0xC0. The address is the low EE_AW bits of {byte2[1:0], byte3}. A write stores byte 4 and holds `busy` for CLK_KHZ*EE_US/1000 cycles. After block reset, all memories read 0xFF.
- R7: While `busy` is high, erase, page-load, page-write and EEPROM-write frames are dropped and do not extend the timer. Read frames still return data.
- R8: A frame whose first byte matches no command changes no memory, does not raise `busy`, and returns 0x00 in its fourth byte.
- R9: In any frame whose first byte is 0xAC, the second byte is echoed on MISO while the third byte is shifted.
- R10: Raising `tgt_rst` clears the enable state, resets the bit counter to zero and forces MISO low. A frame sent after `tgt_rst` falls again is aligned from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| tgt_rst | input | 1 | Session pin; low opens a programming session, high closes it |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| busy | output | 1 | High while an erase or write delay is running |

## Verification
The bench reads back every program-memory word, both halves, and every EEPROM byte after each kind of modification, so an address-slicing error shows up as misplaced data. A design that ignored H would return the low byte twice, and one that shifted LSB first would return bit-reversed values. A page write issued with no loads checks that the staging buffer was refilled with ones; a design that skipped the refill would copy the previous page into it. A write sent while a delay is still running checks that it is dropped; a design without the busy gate would overwrite the byte. A session pulse in the middle of a frame checks re-alignment; a design that kept its bit count would echo a shifted handshake byte.

// File: rtl/isp_pkg.sv
package isp_pkg;

  localparam logic [7:0] OP_ENTER    = 8'hAC;
  localparam logic [7:0] ARG_ENTER   = 8'h53;
  localparam logic [7:0] OP_PM_READ  = 8'h20;
  localparam logic [7:0] OP_PG_LOAD  = 8'h40;
  localparam logic [7:0] OP_PG_WRITE = 8'h4C;
  localparam logic [7:0] OP_EE_READ  = 8'hA0;
  localparam logic [7:0] OP_EE_WRITE = 8'hC0;
  localparam logic [7:0] HSEL_MASK   = 8'hF7;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_ENABLE,
    CMD_ERASE,
    CMD_PGLOAD,
    CMD_PGWRITE,
    CMD_EEWRITE
  } cmd_e;

  function automatic cmd_e classify(input logic [7:0] op, input logic [7:0] arg);
    if (op == OP_ENTER && arg == ARG_ENTER)        return CMD_ENABLE;
    else if (op == OP_ENTER && arg[7:5] == 3'b100) return CMD_ERASE;
    else if ((op & HSEL_MASK) == OP_PG_LOAD)       return CMD_PGLOAD;
    else if (op == OP_PG_WRITE)                    return CMD_PGWRITE;
    else if (op == OP_EE_WRITE)                    return CMD_EEWRITE;
    else                                           return CMD_NONE;
  endfunction

endpackage

// File: rtl/isp_spi_shifter.sv
module isp_spi_shifter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sck_i,
  input  logic        mosi_i,
  input  logic        tgt_rst_i,
  input  logic [7:0]  tx_load_i,
  output logic        sess_off_o,
  output logic [4:0]  bit_cnt_o,
  output logic [31:0] shift_o,
  output logic        frame_v_o,
  output logic        miso_o
);

  logic [2:0]  sck_q;
  logic [1:0]  mosi_q;
  logic [1:0]  sess_q;
  logic        rise, fall;
  logic [4:0]  cnt_d, cnt_q;
  logic [31:0] sr_d, sr_q;
  logic [7:0]  tx_d, tx_q;
  logic        fv_d, fv_q;

  // input synchronisers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 3'b000;
      mosi_q <= 2'b00;
      sess_q <= 2'b11;
    end else begin
      sck_q  <= {sck_q[1:0], sck_i};
      mosi_q <= {mosi_q[0], mosi_i};
      sess_q <= {sess_q[0], tgt_rst_i};
    end
  end

  assign sess_off_o = sess_q[1];
  assign rise       = sck_q[1] & ~sck_q[2];
  assign fall       = ~sck_q[1] & sck_q[2];

  always_comb begin
    cnt_d = cnt_q;
    sr_d  = sr_q;
    tx_d  = tx_q;
    fv_d  = 1'b0;
    if (sess_off_o) begin
      cnt_d = 5'd0;
      tx_d  = 8'h00;
    end else if (rise) begin
      sr_d  = {sr_q[30:0], mosi_q[1]};
      cnt_d = cnt_q + 5'd1;
      fv_d  = (cnt_q == 5'd31);
    end else if (fall) begin
      // byte boundary: present the next outgoing byte, else shift
      tx_d = (cnt_q[2:0] == 3'd0) ? tx_load_i : {tx_q[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= 5'd0;
      sr_q  <= 32'd0;
      tx_q  <= 8'h00;
      fv_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sr_q  <= sr_d;
      tx_q  <= tx_d;
      fv_q  <= fv_d;
    end
  end

  assign bit_cnt_o = cnt_q;
  assign shift_o   = sr_q;
  assign frame_v_o = fv_q;
  assign miso_o    = tx_q[7];

endmodule

// File: rtl/isp_mem.sv
module isp_mem #(
  parameter int PM_AW = 8,
  parameter int PG_W  = 4,
  parameter int EE_AW = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  erase_i,
  input  logic                  pg_ld_i,
  input  logic                  pg_hi_i,
  input  logic [PG_W-1:0]       pg_idx_i,
  input  logic [7:0]            pg_data_i,
  input  logic                  pg_wr_i,
  input  logic [PM_AW-PG_W-1:0] pg_page_i,
  input  logic                  ee_wr_i,
  input  logic [EE_AW-1:0]      ee_waddr_i,
  input  logic [7:0]            ee_wdata_i,
  input  logic [PM_AW-1:0]      pm_raddr_i,
  output logic [15:0]           pm_rdata_o,
  input  logic [EE_AW-1:0]      ee_raddr_i,
  output logic [7:0]            ee_rdata_o
);

  localparam int PM_WORDS = 1 << PM_AW;
  localparam int PG_WORDS = 1 << PG_W;
  localparam int EE_BYTES = 1 << EE_AW;

  logic [15:0] pm   [PM_WORDS];
  logic [15:0] pbuf [PG_WORDS];
  logic [7:0]  ee   [EE_BYTES];

  // program memory
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PM_WORDS; i++) pm[i] <= 16'hFFFF;
    end else if (erase_i) begin
      for (int i = 0; i < PM_WORDS; i++) pm[i] <= 16'hFFFF;
    end else if (pg_wr_i) begin
      for (int j = 0; j < PG_WORDS; j++) pm[{pg_page_i, PG_W'(j)}] <= pbuf[j];
    end
  end

  // page staging buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < PG_WORDS; j++) pbuf[j] <= 16'hFFFF;
    end else if (erase_i || pg_wr_i) begin
      for (int j = 0; j < PG_WORDS; j++) pbuf[j] <= 16'hFFFF;
    end else if (pg_ld_i) begin
      if (pg_hi_i) pbuf[pg_idx_i][15:8] <= pg_data_i;
      else         pbuf[pg_idx_i][7:0]  <= pg_data_i;
    end
  end

  // EEPROM
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < EE_BYTES; k++) ee[k] <= 8'hFF;
    end else if (erase_i) begin
      for (int k = 0; k < EE_BYTES; k++) ee[k] <= 8'hFF;
    end else if (ee_wr_i) begin
      ee[ee_waddr_i] <= ee_wdata_i;
    end
  end

  assign pm_rdata_o = pm[pm_raddr_i];
  assign ee_rdata_o = ee[ee_raddr_i];

endmodule

// File: rtl/isp_target.sv
module isp_target
  import isp_pkg::*;
#(
  parameter int CLK_KHZ  = 20000,
  parameter int ERASE_US = 9000,
  parameter int FLASH_US = 4500,
  parameter int EE_US    = 3600,
  parameter int PM_AW    = 8,
  parameter int PG_W     = 4,
  parameter int EE_AW    = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgt_rst,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  output logic busy
);

  localparam int ERASE_CYC = CLK_KHZ * ERASE_US / 1000;
  localparam int FLASH_CYC = CLK_KHZ * FLASH_US / 1000;
  localparam int EE_CYC    = CLK_KHZ * EE_US / 1000;
  localparam int MAX_A     = (ERASE_CYC > FLASH_CYC) ? ERASE_CYC : FLASH_CYC;
  localparam int MAX_CYC   = (MAX_A > EE_CYC) ? MAX_A : EE_CYC;
  localparam int BUSY_W    = $clog2(MAX_CYC + 1);
  localparam logic [BUSY_W-1:0] ERASE_N = BUSY_W'(ERASE_CYC);
  localparam logic [BUSY_W-1:0] FLASH_N = BUSY_W'(FLASH_CYC);
  localparam logic [BUSY_W-1:0] EE_N    = BUSY_W'(EE_CYC);

  logic              sess_off;
  logic [4:0]        bit_cnt;
  logic [31:0]       sr;
  logic              frame_v;
  logic [7:0]        tx_load;
  logic [15:0]       pm_rdata;
  logic [7:0]        ee_rdata;
  cmd_e              cmd;
  logic              can_mod;
  logic              erase_go, pg_ld_go, pg_wr_go, ee_wr_go;
  logic              en_d, en_q;
  logic [BUSY_W-1:0] busy_d, busy_cnt;

  isp_spi_shifter u_shf (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck_i      (sck),
    .mosi_i     (mosi),
    .tgt_rst_i  (tgt_rst),
    .tx_load_i  (tx_load),
    .sess_off_o (sess_off),
    .bit_cnt_o  (bit_cnt),
    .shift_o    (sr),
    .frame_v_o  (frame_v),
    .miso_o     (miso)
  );

  // frame decode: sr = {op, arg, addr_lo, data}
  assign cmd      = classify(sr[31:24], sr[23:16]);
  assign can_mod  = frame_v && en_q && (busy_cnt == '0);
  assign erase_go = can_mod && (cmd == CMD_ERASE);
  assign pg_ld_go = can_mod && (cmd == CMD_PGLOAD);
  assign pg_wr_go = can_mod && (cmd == CMD_PGWRITE);
  assign ee_wr_go = can_mod && (cmd == CMD_EEWRITE);

  // outgoing byte chosen at byte boundaries (after bits 16 and 24)
  always_comb begin
    tx_load = 8'h00;
    if (bit_cnt == 5'd16 && sr[15:8] == OP_ENTER) begin
      tx_load = sr[7:0];
    end else if (bit_cnt == 5'd24 && en_q) begin
      if ((sr[23:16] & HSEL_MASK) == OP_PM_READ)
        tx_load = sr[19] ? pm_rdata[15:8] : pm_rdata[7:0];
      else if (sr[23:16] == OP_EE_READ)
        tx_load = ee_rdata;
    end
  end

  always_comb begin
    en_d = en_q;
    if (sess_off)                             en_d = 1'b0;
    else if (frame_v && cmd == CMD_ENABLE)    en_d = 1'b1;
    busy_d = busy_cnt;
    if (erase_go)                 busy_d = ERASE_N;
    else if (pg_wr_go)            busy_d = FLASH_N;
    else if (ee_wr_go)            busy_d = EE_N;
    else if (busy_cnt != '0)      busy_d = busy_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      busy_cnt <= '0;
    end else begin
      en_q     <= en_d;
      busy_cnt <= busy_d;
    end
  end

  assign busy = (busy_cnt != '0);

  isp_mem #(.PM_AW(PM_AW), .PG_W(PG_W), .EE_AW(EE_AW)) u_mem (
    .clk        (clk),
    .rst_n      (rst_n),
    .erase_i    (erase_go),
    .pg_ld_i    (pg_ld_go),
    .pg_hi_i    (sr[27]),
    .pg_idx_i   (sr[8+PG_W-1:8]),
    .pg_data_i  (sr[7:0]),
    .pg_wr_i    (pg_wr_go),
    .pg_page_i  (sr[8+PM_AW-1:8+PG_W]),
    .ee_wr_i    (ee_wr_go),
    .ee_waddr_i (sr[8+EE_AW-1:8]),
    .ee_wdata_i (sr[7:0]),
    .pm_raddr_i (sr[PM_AW-1:0]),
    .pm_rdata_o (pm_rdata),
    .ee_raddr_i (sr[EE_AW-1:0]),
    .ee_rdata_o (ee_rdata)
  );

endmodule

// File: rtl/isp_target_chk.sv
module isp_target_chk #(
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sess_off,
  input logic          frame_v,
  input logic          en_q,
  input logic [BW-1:0] busy_cnt,
  input logic [4:0]    bit_cnt,
  input logic          miso
);

  AST_ENABLE_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(frame_v)); // R2

  AST_WRITE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_cnt != '0) |-> $past(en_q)); // R2

  AST_BUSY_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_cnt != '0) |-> $past(frame_v)); // R3

  AST_BUSY_KEEPS_COUNTING: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_cnt != '0) && frame_v |=> busy_cnt == $past(busy_cnt) - 1'b1); // R7

  AST_IDLE_CLEARS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    sess_off |=> !en_q && bit_cnt == 5'd0); // R10

  AST_IDLE_MISO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sess_off && $past(sess_off) |-> !miso); // R10

endmodule

bind isp_target isp_target_chk #(.BW(BUSY_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sess_off (sess_off),
  .frame_v  (frame_v),
  .en_q     (en_q),
  .busy_cnt (busy_cnt),
  .bit_cnt  (bit_cnt),
  .miso     (miso)
);

// File: tb/isp_target_test.sv
`timescale 1ns/1ps
module isp_target_test;

  localparam int CLK_KHZ  = 100;
  localparam int ERASE_US = 9000;
  localparam int FLASH_US = 4500;
  localparam int EE_US    = 3600;
  localparam int PM_AW    = 5;
  localparam int PG_W     = 3;
  localparam int EE_AW    = 4;
  localparam int ERASE_CYC = CLK_KHZ * ERASE_US / 1000;
  localparam int FLASH_CYC = CLK_KHZ * FLASH_US / 1000;
  localparam int EE_CYC    = CLK_KHZ * EE_US / 1000;
  localparam int PM_WORDS  = 1 << PM_AW;
  localparam int PG_WORDS  = 1 << PG_W;
  localparam int EE_BYTES  = 1 << EE_AW;
  localparam int HALF = 4;
  localparam int GAP  = 6;
  localparam int SKIP = 5;

  logic clk = 1'b0;
  logic rst_n, tgt_rst, sck, mosi;
  logic miso, busy;
  int   n_chk = 0;
  int   n_fail = 0;
  int   run = 0;
  int   last_run = 0;
  logic [31:0] rx;
  logic [7:0]  v;

  always #2.5 clk = ~clk;

  isp_target #(
    .CLK_KHZ(CLK_KHZ), .ERASE_US(ERASE_US), .FLASH_US(FLASH_US), .EE_US(EE_US),
    .PM_AW(PM_AW), .PG_W(PG_W), .EE_AW(EE_AW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .tgt_rst(tgt_rst), .sck(sck),
    .mosi(mosi), .miso(miso), .busy(busy)
  );

  // length of the most recent busy stretch
  always @(negedge clk) begin
    if (busy) run++;
    else begin
      if (run != 0) last_run = run;
      run = 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                      input logic [7:0] d, output logic [31:0] r);
    logic [31:0] w;
    w = {a, b, c, d};
    for (int i = 31; i >= 0; i--) begin
      mosi = w[i];
      repeat (HALF) @(negedge clk);
      r[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (GAP) @(negedge clk);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
    @(negedge clk);
  endtask

  function automatic logic [7:0] lo_val(input int j);
    return 8'h30 | 8'(j);
  endfunction
  function automatic logic [7:0] hi_val(input int j);
    return 8'hC0 | 8'(j);
  endfunction
  function automatic logic [7:0] ee_val(input int a);
    return 8'hA5 ^ 8'(a * 19);
  endfunction
  function automatic logic [7:0] pm_exp(input int w, input bit hi);
    if ((w / PG_WORDS) == 1 && (w % PG_WORDS) != SKIP)
      return hi ? hi_val(w % PG_WORDS) : lo_val(w % PG_WORDS);
    return 8'hFF;
  endfunction

  task automatic rd_pm(input int w, input bit hi, output logic [7:0] q);
    logic [31:0] r;
    xfer({4'b0010, hi, 3'b000}, 8'(w >> 8), 8'(w), 8'h00, r);
    q = r[7:0];
  endtask
  task automatic rd_ee(input int a, output logic [7:0] q);
    logic [31:0] r;
    xfer(8'hA0, 8'(a >> 8), 8'(a), 8'h00, r);
    q = r[7:0];
  endtask
  task automatic wr_ee(input int a, input logic [7:0] d);
    logic [31:0] r;
    xfer(8'hC0, 8'(a >> 8), 8'(a), d, r);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tgt_rst = 1'b1; sck = 1'b0; mosi = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10 reset miso", 32'(miso), 32'd0);
    chk("R10 reset busy", 32'(busy), 32'd0);

    // handshake while the session pin is high is ignored
    xfer(8'hAC, 8'h53, 8'h00, 8'h00, rx);
    chk("R10 no echo while idle", 32'(rx[15:8]), 32'h00);
    tgt_rst = 1'b0;
    repeat (5) @(negedge clk);
    rd_ee(2, v);
    chk("R2 read before enable", 32'(v), 32'h00);
    wr_ee(2, 8'h77);
    chk("R2 no busy before enable", 32'(busy), 32'd0);

    xfer(8'hAC, 8'h53, 8'h00, 8'h00, rx);
    chk("R9 echo of second byte", 32'(rx[15:8]), 32'h53);
    rd_ee(2, v);
    chk("R2 write before enable dropped", 32'(v), 32'hFF);
    chk("R6 reset value", 32'(v), 32'hFF);

    // stage page 1 (one word left unloaded), commit
    for (int j = 0; j < PG_WORDS; j++) begin
      if (j != SKIP) begin
        xfer(8'h40, 8'h00, 8'(j), lo_val(j), rx);
        xfer(8'h48, 8'h00, 8'(j), hi_val(j), rx);
      end
    end
    xfer(8'h4C, 8'h00, 8'(PG_WORDS), 8'h00, rx);
    rd_pm(PG_WORDS + 2, 1'b1, v);
    chk("R7 read during busy", 32'(v), 32'(hi_val(2)));
    chk("R7 still busy", 32'(busy), 32'd1);
    wait_idle();
    chk("R5 page write delay", 32'(last_run), 32'(FLASH_CYC));

    // page 2 with no loads: buffer must have been refilled with ones
    xfer(8'h4C, 8'h00, 8'(2 * PG_WORDS), 8'h00, rx);
    wait_idle();
    for (int w = 0; w < PM_WORDS; w++) begin
      for (int h = 0; h < 2; h++) begin
        rd_pm(w, h[0], v);
        chk("R1 R4 R5 program memory", 32'(v), 32'(pm_exp(w, h[0])));
      end
    end

    // EEPROM fill and read back
    for (int a = 0; a < EE_BYTES; a++) begin
      wr_ee(a, ee_val(a));
      wait_idle();
      if (a == 0) chk("R6 eeprom write delay", 32'(last_run), 32'(EE_CYC));
    end
    for (int a = 0; a < EE_BYTES; a++) begin
      rd_ee(a, v);
      chk("R6 eeprom read", 32'(v), 32'(ee_val(a)));
    end

    // second write lands while the first delay is running
    wr_ee(0, 8'h11);
    wr_ee(1, 8'h22);
    wait_idle();
    chk("R7 delay not extended", 32'(last_run), 32'(EE_CYC));
    rd_ee(0, v);
    chk("R7 first write taken", 32'(v), 32'h11);
    rd_ee(1, v);
    chk("R7 write while busy dropped", 32'(v), 32'(ee_val(1)));

    // unknown opcodes
    xfer(8'hC4, 8'h00, 8'h03, 8'h00, rx);
    chk("R8 unknown returns zero", 32'(rx[7:0]), 32'h00);
    chk("R8 unknown no busy", 32'(busy), 32'd0);
    xfer(8'hAD, 8'h80, 8'h00, 8'h00, rx);
    chk("R8 near-erase no busy", 32'(busy), 32'd0);
    rd_ee(3, v);
    chk("R8 memory untouched", 32'(v), 32'(ee_val(3)));

    // chip erase
    xfer(8'hAC, 8'h80, 8'h00, 8'h00, rx);
    xfer(8'hC0, 8'h00, 8'h04, 8'h5A, rx);
    wait_idle();
    chk("R3 erase delay", 32'(last_run), 32'(ERASE_CYC));
    for (int a = 0; a < EE_BYTES; a++) begin
      rd_ee(a, v);
      chk("R3 eeprom erased", 32'(v), 32'hFF);
    end
    for (int w = 0; w < PM_WORDS; w++) begin
      rd_pm(w, w[0], v);
      chk("R3 program memory erased", 32'(v), 32'hFF);
    end

    // session pulse mid-frame
    for (int i = 0; i < 12; i++) begin
      mosi = i[0];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    tgt_rst = 1'b1;
    repeat (10) @(negedge clk);
    chk("R10 miso low in idle", 32'(miso), 32'd0);
    tgt_rst = 1'b0;
    repeat (10) @(negedge clk);
    wr_ee(5, 8'h66);
    chk("R10 enable cleared", 32'(busy), 32'd0);
    xfer(8'hAC, 8'h53, 8'h00, 8'h00, rx);
    chk("R10 R1 frame realigned", 32'(rx[15:8]), 32'h53);
    wr_ee(5, 8'h69);
    wait_idle();
    rd_ee(5, v);
    chk("R10 new session works", 32'(v), 32'h69);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule